// File: doc/BRIEF.md
# Center-Aligned PWM Channel Pair

This block is a timer counter with a prescaler, a programmable top value and a repetition count. It can count up, count down, or count up and down for center-aligned waveforms. Two compare channels share the counter. Each channel makes a PWM reference level, and a pair selector merges the two channels into one more output. That output can be a single-channel PWM, an asymmetric center-aligned PWM, or an OR or AND of the two channel references.

The prescaler, top value, repetition count and both compare values are written to preload inputs. They become active only on an update event. An update event happens at the counter turn points once the repetition count runs out, or when software asks for one. A disable input holds off counter-driven updates, so the active values stay as they are. The update pulse output marks the cycle in which newly loaded values are first in use.

Top module: `cpwm_pair`

## Requirements
- R1: In up mode (`cnt_mode`=0) the counter steps 0,1,..,top and then back to 0. Leaving top is a hardware update event. After reset the counter is 0 and `upd_o` is 0.
- R2: In down mode (`cnt_mode`=1) the counter steps top,..,1,0 and then reloads top. Leaving 0 is a hardware update event. `dir_o` reads 1 in this mode.
- R3: In center mode (`cnt_mode`=2) the counter runs 0 up to top and back down to 0. Each endpoint is held for one count only. `dir_o` is 1 while counting down. Leaving top and leaving 0 are both hardware update events.
- R4: The counter advances once per psc+1 enabled clocks. While `cnt_en` is 0, the counter and the prescaler phase are held.
- R5: Only every (rep+1)-th hardware event becomes an update, so the update period is (psc+1)·(top+1)·(rep+1) clocks in up mode.
- R6: The prescaler, top, repetition and compare values take effect only on an update. `upd_o` is high for exactly the first cycle in which the new values are active.
- R7: While `upd_dis` is 1, hardware events give no `upd_o` pulse and load nothing. The counter keeps wrapping at the active top.
- R8: A cycle with `gen_upd`=1 takes priority over counting. It loads all preloads, restarts the prescaler and the repetition count, and sets the counter to 0 counting up. In down mode it sets the counter to the preloaded top instead. `upd_o` pulses in the next cycle.
- R9: Channel reference while counting up is (cnt < cmp). While counting down it is (cnt <= cmp). This is PWM mode 1. When `inv_x`=1 the level is inverted, which is PWM mode 2.
- R10: `pair_mode`=4'b0110 outputs channel A in PWM mode 1. `pair_mode`=4'b0111 outputs channel A in PWM mode 2. Both ignore `inv_a`.
- R11: `pair_mode`=4'b1110 is asymmetric mode 1. It outputs channel A's mode-1 level while counting up and channel B's mode-1 level while counting down. `pair_mode`=4'b1111 outputs the inverse of that.
- R12: `pair_mode`=4'b1100 outputs `ref_a` OR `ref_b`. `pair_mode`=4'b1101 outputs `ref_a` AND `ref_b`.
- R13: Any other `pair_mode` drives `pair_ref` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Counter enable |
| gen_upd | input | 1 | Software update request |
| upd_dis | input | 1 | Suppress counter-driven updates |
| cnt_mode | input | 2 | 0 up, 1 down, 2 center |
| psc_pre | input | PSC_W | Prescaler preload |
| top_pre | input | CNT_W | Top (period) preload |
| rep_pre | input | RCR_W | Repetition count preload |
| cmp_a_pre | input | CNT_W | Channel A compare preload |
| cmp_b_pre | input | CNT_W | Channel B compare preload |
| inv_a | input | 1 | Channel A PWM mode 2 select |
| inv_b | input | 1 | Channel B PWM mode 2 select |
| pair_mode | input | 4 | Pair output selector |
| cnt_o | output | CNT_W | Counter value |
| dir_o | output | 1 | 1 while counting down |
| ref_a | output | 1 | Channel A reference |
| ref_b | output | 1 | Channel B reference |
| pair_ref | output | 1 | Merged pair reference |
| upd_o | output | 1 | Update pulse |

## Verification
The bench checks the center-mode turn points cycle by cycle. A design that repeated top or 0, or that turned one count late, would produce a wrong count pattern and a wrong asymmetric waveform. It changes preloads in the middle of a period and sets the disable input. A design that loaded at once, or loaded while disabled, would wrap at the wrong count. It also checks the repetition spacing and a prescaler phase held across an enable gap, where an off-by-one shifts every later update. The OR and AND cases use references with differing waveforms, so swapping the two operators shows up.

// File: rtl/cpwm_pkg.sv
// Shared types and selector codes for the PWM channel pair.
package cpwm_pkg;
    typedef enum logic [1:0] {
        CNT_UP     = 2'd0,
        CNT_DOWN   = 2'd1,
        CNT_CENTER = 2'd2
    } cnt_mode_e;

    localparam logic [3:0] PM_PWM1     = 4'b0110;
    localparam logic [3:0] PM_PWM2     = 4'b0111;
    localparam logic [3:0] PM_COMB_OR  = 4'b1100;
    localparam logic [3:0] PM_COMB_AND = 4'b1101;
    localparam logic [3:0] PM_ASYM1    = 4'b1110;
    localparam logic [3:0] PM_ASYM2    = 4'b1111;
endpackage

// File: rtl/cpwm_prescaler.sv
// Clock divider: gives one tick every psc_lim+1 enabled cycles.
// Assumes restart has priority and clears the phase.
module cpwm_prescaler #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             restart,
    input  logic [PSC_W-1:0] psc_lim,
    output logic             tick
);
    logic [PSC_W-1:0] div_q;

    assign tick = en && !restart && (div_q >= psc_lim);

    // Divider phase: clear on restart, advance while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)       div_q <= '0;
        else if (restart) div_q <= '0;
        else if (en)      div_q <= tick ? '0 : div_q + PSC_W'(1);
    end
endmodule

// File: rtl/cpwm_counter.sv
// Up/down/center counter with turn-point detection.
// Assumes top_act is stable between updates; `load` picks the reload value on a down wrap.
module cpwm_counter
    import cpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cnt_mode_e        mode,
    input  logic             tick,
    input  logic             restart,
    input  logic             load,
    input  logic [CNT_W-1:0] top_act,
    input  logic [CNT_W-1:0] top_pre,
    output logic [CNT_W-1:0] cnt,
    output logic             down,
    output logic             wrap
);
    logic [CNT_W-1:0] cnt_q, cnt_d, top_next;
    logic             dn_q, dn_d, at_end;

    assign top_next = load ? top_pre : top_act;

    // Endpoint detection for the current direction.
    always_comb begin
        case (mode)
            CNT_DOWN:   at_end = (cnt_q == '0);
            CNT_CENTER: at_end = dn_q ? (cnt_q == '0) : (cnt_q >= top_act);
            default:    at_end = (cnt_q >= top_act);
        endcase
    end

    assign wrap = tick && at_end;

    // Next count and direction.
    always_comb begin
        cnt_d = cnt_q;
        dn_d  = dn_q;
        if (restart) begin
            cnt_d = (mode == CNT_DOWN) ? top_pre : '0;
            dn_d  = (mode == CNT_DOWN);
        end else if (tick) begin
            case (mode)
                CNT_DOWN: begin
                    cnt_d = at_end ? top_next : cnt_q - CNT_W'(1);
                    dn_d  = 1'b1;
                end
                CNT_CENTER: begin
                    if (top_act == '0) begin
                        cnt_d = '0;
                        dn_d  = !dn_q;
                    end else if (!dn_q) begin
                        cnt_d = at_end ? top_act - CNT_W'(1) : cnt_q + CNT_W'(1);
                        dn_d  = at_end;
                    end else begin
                        cnt_d = at_end ? CNT_W'(1) : cnt_q - CNT_W'(1);
                        dn_d  = !at_end;
                    end
                end
                default: begin
                    cnt_d = at_end ? '0 : cnt_q + CNT_W'(1);
                    dn_d  = 1'b0;
                end
            endcase
        end
    end

    // Count and direction registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            dn_q  <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            dn_q  <= dn_d;
        end
    end

    assign cnt  = cnt_q;
    assign down = (mode == CNT_DOWN) || ((mode == CNT_CENTER) && dn_q);
endmodule

// File: rtl/cpwm_chan_ref.sv
// One compare channel: mode-1 PWM level, inverted for mode 2.
// Assumes cmp is the active (buffered) compare value.
module cpwm_chan_ref #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    input  logic             down,
    input  logic             inv,
    output logic             ref_o
);
    logic lvl;

    // Mode-1 level depends on the counting direction.
    always_comb lvl = down ? (cnt <= cmp) : (cnt < cmp);

    assign ref_o = lvl ^ inv;
endmodule

// File: rtl/cpwm_pair_mux.sv
// Pair selector: single, asymmetric or combined output from two channels.
// Assumes asymmetric codes are used with center counting.
module cpwm_pair_mux
    import cpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    input  logic             down,
    input  logic             ref_a,
    input  logic             ref_b,
    input  logic [3:0]       pair_mode,
    output logic             pair_ref
);
    logic lvl_a, lvl_b, asym;

    // Mode-1 levels of both channels, independent of their invert inputs.
    always_comb begin
        lvl_a = down ? (cnt <= cmp_a) : (cnt < cmp_a);
        lvl_b = down ? (cnt <= cmp_b) : (cnt < cmp_b);
        asym  = down ? lvl_b : lvl_a;
    end

    // Output select by pair code.
    always_comb begin
        case (pair_mode)
            PM_PWM1:     pair_ref = lvl_a;
            PM_PWM2:     pair_ref = !lvl_a;
            PM_COMB_OR:  pair_ref = ref_a | ref_b;
            PM_COMB_AND: pair_ref = ref_a & ref_b;
            PM_ASYM1:    pair_ref = asym;
            PM_ASYM2:    pair_ref = !asym;
            default:     pair_ref = 1'b0;
        endcase
    end
endmodule

// File: rtl/cpwm_pair.sv
// Timer with buffered period/prescaler/compare values driving a PWM channel pair.
// Assumes a gen_upd is issued after changing cnt_mode.
module cpwm_pair
    import cpwm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16,
    parameter int RCR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             gen_upd,
    input  logic             upd_dis,
    input  logic [1:0]       cnt_mode,
    input  logic [PSC_W-1:0] psc_pre,
    input  logic [CNT_W-1:0] top_pre,
    input  logic [RCR_W-1:0] rep_pre,
    input  logic [CNT_W-1:0] cmp_a_pre,
    input  logic [CNT_W-1:0] cmp_b_pre,
    input  logic             inv_a,
    input  logic             inv_b,
    input  logic [3:0]       pair_mode,
    output logic [CNT_W-1:0] cnt_o,
    output logic             dir_o,
    output logic             ref_a,
    output logic             ref_b,
    output logic             pair_ref,
    output logic             upd_o
);
    localparam int NCH = 2;

    cnt_mode_e        mode;
    logic [PSC_W-1:0] psc_act;
    logic [CNT_W-1:0] top_act;
    logic [RCR_W-1:0] rcr_act, rep_q;
    logic [CNT_W-1:0] cmp_pre [NCH];
    logic [CNT_W-1:0] cmp_act [NCH];
    logic             inv_v   [NCH];
    logic             ref_v   [NCH];
    logic             tick, wrap, uev, upd_q, down;

    assign mode       = cnt_mode_e'(cnt_mode);
    assign cmp_pre[0] = cmp_a_pre;
    assign cmp_pre[1] = cmp_b_pre;
    assign inv_v[0]   = inv_a;
    assign inv_v[1]   = inv_b;

    // Update event: software request, or an unsuppressed event with repetition exhausted.
    assign uev = gen_upd || (wrap && (rep_q == '0) && !upd_dis);

    cpwm_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cnt_en),
        .restart (gen_upd),
        .psc_lim (psc_act),
        .tick    (tick)
    );

    cpwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .tick    (tick),
        .restart (gen_upd),
        .load    (uev),
        .top_act (top_act),
        .top_pre (top_pre),
        .cnt     (cnt_o),
        .down    (down),
        .wrap    (wrap)
    );

    // Shadow registers: copy preloads on every update event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psc_act <= '0;
            top_act <= '0;
            rcr_act <= '0;
            for (int i = 0; i < NCH; i++) cmp_act[i] <= '0;
        end else if (uev) begin
            psc_act <= psc_pre;
            top_act <= top_pre;
            rcr_act <= rep_pre;
            for (int i = 0; i < NCH; i++) cmp_act[i] <= cmp_pre[i];
        end
    end

    // Repetition down-counter over hardware events.
    always_ff @(posedge clk) begin
        if (!rst_n)       rep_q <= '0;
        else if (gen_upd) rep_q <= rep_pre;
        else if (wrap) begin
            if (rep_q == '0) rep_q <= uev ? rep_pre : rcr_act;
            else             rep_q <= rep_q - RCR_W'(1);
        end
    end

    // Update pulse aligned with the first cycle of new active values.
    always_ff @(posedge clk) begin
        if (!rst_n) upd_q <= 1'b0;
        else        upd_q <= uev;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        cpwm_chan_ref #(.CNT_W(CNT_W)) u_ref (
            .cnt   (cnt_o),
            .cmp   (cmp_act[g]),
            .down  (down),
            .inv   (inv_v[g]),
            .ref_o (ref_v[g])
        );
    end

    cpwm_pair_mux #(.CNT_W(CNT_W)) u_mux (
        .cnt       (cnt_o),
        .cmp_a     (cmp_act[0]),
        .cmp_b     (cmp_act[1]),
        .down      (down),
        .ref_a     (ref_v[0]),
        .ref_b     (ref_v[1]),
        .pair_mode (pair_mode),
        .pair_ref  (pair_ref)
    );

    assign ref_a = ref_v[0];
    assign ref_b = ref_v[1];
    assign dir_o = down;
    assign upd_o = upd_q;
endmodule

// File: rtl/cpwm_pair_chk.sv
// Property checker for cpwm_pair, attached by bind.
module cpwm_pair_chk
    import cpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_en,
    input logic             gen_upd,
    input logic             upd_dis,
    input logic [1:0]       cnt_mode,
    input logic [3:0]       pair_mode,
    input logic [CNT_W-1:0] cnt_o,
    input logic             upd_o,
    input logic             ref_a,
    input logic             ref_b,
    input logic             pair_ref,
    input logic [CNT_W-1:0] cmp_a_act
);
    a_r4_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !gen_upd) |=> $stable(cnt_o));

    a_r7_no_update_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_dis && !gen_upd) |=> !upd_o);

    a_r8_sw_update_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_upd && (cnt_mode != 2'd1)) |=> (upd_o && (cnt_o == '0)));

    a_r6_cmp_held: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_o |-> $stable(cmp_a_act));

    a_r12_or_merge: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_mode == PM_COMB_OR) |-> (pair_ref == (ref_a | ref_b)));

    a_r12_and_merge: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_mode == PM_COMB_AND) |-> (pair_ref == (ref_a & ref_b)));
endmodule

bind cpwm_pair cpwm_pair_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_en    (cnt_en),
    .gen_upd   (gen_upd),
    .upd_dis   (upd_dis),
    .cnt_mode  (cnt_mode),
    .pair_mode (pair_mode),
    .cnt_o     (cnt_o),
    .upd_o     (upd_o),
    .ref_a     (ref_a),
    .ref_b     (ref_b),
    .pair_ref  (pair_ref),
    .cmp_a_act (cmp_act[0])
);

// File: tb/cpwm_pair_tb.sv
// Directed bench for cpwm_pair: one task per scenario.
module cpwm_pair_tb;
    localparam int CLK_P = 10;
    localparam int CW = 16, PW = 16, RW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cnt_en = 1'b0, gen_upd = 1'b0, upd_dis = 1'b0;
    logic [1:0]    cnt_mode = 2'd0;
    logic [PW-1:0] psc_pre = '0;
    logic [CW-1:0] top_pre = '0, cmp_a_pre = '0, cmp_b_pre = '0;
    logic [RW-1:0] rep_pre = '0;
    logic          inv_a = 1'b0, inv_b = 1'b0;
    logic [3:0]    pair_mode = 4'b0000;
    logic [CW-1:0] cnt_o;
    logic          dir_o, ref_a, ref_b, pair_ref, upd_o;
    int            n_run = 0, n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    cpwm_pair #(.CNT_W(CW), .PSC_W(PW), .RCR_W(RW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .gen_upd(gen_upd),
        .upd_dis(upd_dis), .cnt_mode(cnt_mode), .psc_pre(psc_pre),
        .top_pre(top_pre), .rep_pre(rep_pre), .cmp_a_pre(cmp_a_pre),
        .cmp_b_pre(cmp_b_pre), .inv_a(inv_a), .inv_b(inv_b),
        .pair_mode(pair_mode), .cnt_o(cnt_o), .dir_o(dir_o), .ref_a(ref_a),
        .ref_b(ref_b), .pair_ref(pair_ref), .upd_o(upd_o)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic setup(input int md, input int psc, input int top, input int rep,
                         input int ca, input int cb, input bit ia, input bit ib,
                         input logic [3:0] pm);
        cnt_mode = md[1:0]; psc_pre = PW'(psc); top_pre = CW'(top); rep_pre = RW'(rep);
        cmp_a_pre = CW'(ca); cmp_b_pre = CW'(cb); inv_a = ia; inv_b = ib;
        pair_mode = pm; cnt_en = 1'b1; upd_dis = 1'b0;
        gen_upd = 1'b1;
        step();
        gen_upd = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        check("R1", "reset count", int'(cnt_o), 0);
        check("R1", "reset upd", int'(upd_o), 0);
        check("R9", "reset ref_a", int'(ref_a), 0);
        check("R13", "reset pair", int'(pair_ref), 0);
    endtask

    task automatic t_up();
        setup(0, 0, 4, 0, 2, 3, 1'b0, 1'b1, 4'b0110);
        for (int k = 0; k < 12; k++) begin
            int c;
            if (k > 0) step();
            c = k % 5;
            check("R1", "up count", int'(cnt_o), c);
            check("R1", "up upd", int'(upd_o), int'(c == 0));
            check("R9", "pwm1 up", int'(ref_a), int'(c < 2));
            check("R9", "pwm2 up", int'(ref_b), int'(c >= 3));
            check("R10", "pair pwm1", int'(pair_ref), int'(c < 2));
        end
        pair_mode = 4'b0111;
        #1;
        check("R10", "pair pwm2", int'(pair_ref), int'(!((11 % 5) < 2)));
    endtask

    task automatic t_prescale();
        setup(0, 2, 4, 0, 0, 0, 1'b0, 1'b0, 4'b0000);
        for (int k = 1; k <= 20; k++) begin
            step();
            check("R4", "psc count", int'(cnt_o), (k / 3) % 5);
            check("R4", "psc upd", int'(upd_o), int'(k % 15 == 0));
        end
        cnt_en = 1'b0;
        for (int k = 0; k < 5; k++) begin
            step();
            check("R4", "hold count", int'(cnt_o), 1);
        end
        cnt_en = 1'b1;
        step();
        check("R4", "phase kept", int'(cnt_o), 2);
    endtask

    task automatic t_down();
        setup(1, 0, 4, 0, 2, 1, 1'b0, 1'b1, 4'b0000);
        for (int k = 0; k < 12; k++) begin
            int c;
            if (k > 0) step();
            c = 4 - (k % 5);
            check("R2", "down count", int'(cnt_o), c);
            check("R2", "down upd", int'(upd_o), int'(k % 5 == 0));
            check("R2", "down dir", int'(dir_o), 1);
            check("R9", "pwm1 down", int'(ref_a), int'(c <= 2));
            check("R9", "pwm2 down", int'(ref_b), int'(!(c <= 1)));
        end
        check("R13", "unused code", int'(pair_ref), 0);
    endtask

    task automatic t_center();
        setup(2, 0, 4, 0, 1, 3, 1'b0, 1'b0, 4'b1110);
        for (int k = 0; k < 20; k++) begin
            int m, c, dn, lv;
            if (k > 0) begin
                pair_mode = (k < 10) ? 4'b1110 : 4'b1111;
                step();
            end
            m  = k % 8;
            c  = (m <= 4) ? m : 8 - m;
            dn = int'((m >= 5) || (m == 0 && k > 0));
            lv = dn ? int'(c <= 3) : int'(c < 1);
            check("R3", "center count", int'(cnt_o), c);
            check("R3", "center dir", int'(dir_o), dn);
            check("R3", "center upd", int'(upd_o), int'(k == 0 || m == 5 || (m == 1 && k > 1)));
            check("R11", "asym", int'(pair_ref), (k < 10) ? lv : 1 - lv);
        end
    endtask

    task automatic t_combined();
        setup(0, 0, 4, 0, 1, 3, 1'b0, 1'b1, 4'b1100);
        for (int k = 0; k < 20; k++) begin
            int c;
            if (k == 10) begin
                pair_mode = 4'b1101;
                inv_b = 1'b0;
            end
            if (k > 0) step();
            c = k % 5;
            if (k < 10) check("R12", "or merge", int'(pair_ref), int'(c == 0 || c >= 3));
            else        check("R12", "and merge", int'(pair_ref), int'(c == 0 && c < 3));
        end
    endtask

    task automatic t_buffer();
        setup(0, 0, 4, 0, 2, 0, 1'b0, 1'b0, 4'b0000);
        step(); step();
        top_pre = CW'(2);
        cmp_a_pre = CW'(0);
        for (int k = 3; k <= 11; k++) begin
            int c;
            step();
            c = (k < 5) ? k : (k - 5) % 3;
            check("R6", "buffered top", int'(cnt_o), c);
            check("R6", "upd on load", int'(upd_o), int'(k >= 5 && (k - 5) % 3 == 0));
            check("R6", "buffered cmp", int'(ref_a), (k < 5) ? int'(c < 2) : 0);
        end
    endtask

    task automatic t_disable();
        setup(0, 0, 4, 0, 0, 0, 1'b0, 1'b0, 4'b0000);
        upd_dis = 1'b1;
        top_pre = CW'(2);
        for (int k = 1; k <= 12; k++) begin
            step();
            check("R7", "disabled count", int'(cnt_o), k % 5);
            check("R7", "no upd", int'(upd_o), 0);
        end
        upd_dis = 1'b0;
        for (int k = 13; k <= 18; k++) begin
            int c;
            step();
            c = (k < 15) ? k % 5 : (k - 15) % 3;
            check("R7", "reenabled count", int'(cnt_o), c);
            check("R7", "reenabled upd", int'(upd_o), int'(k >= 15 && (k - 15) % 3 == 0));
        end
    endtask

    task automatic t_repeat();
        setup(0, 1, 4, 1, 0, 0, 1'b0, 1'b0, 4'b0000);
        for (int k = 1; k <= 41; k++) begin
            step();
            check("R5", "rep count", int'(cnt_o), (k / 2) % 5);
            check("R5", "rep upd", int'(upd_o), int'(k % 20 == 0));
        end
    endtask

    task automatic t_swgen();
        setup(0, 0, 4, 0, 0, 0, 1'b0, 1'b0, 4'b0000);
        repeat (3) step();
        check("R8", "pre count", int'(cnt_o), 3);
        top_pre = CW'(6);
        gen_upd = 1'b1;
        step();
        gen_upd = 1'b0;
        check("R8", "restart count", int'(cnt_o), 0);
        check("R8", "restart upd", int'(upd_o), 1);
        repeat (6) step();
        check("R8", "new top", int'(cnt_o), 6);
        step();
        check("R8", "new wrap", int'(cnt_o), 0);
        cnt_mode = 2'd1;
        top_pre = CW'(3);
        gen_upd = 1'b1;
        step();
        gen_upd = 1'b0;
        check("R8", "down restart", int'(cnt_o), 3);
        check("R8", "down restart upd", int'(upd_o), 1);
    endtask

    initial begin
        #(CLK_P * 100000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_up();
        t_prescale();
        t_down();
        t_center();
        t_combined();
        t_buffer();
        t_disable();
        t_repeat();
        t_swgen();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule